// File: doc/BRIEF.md
# Backlight panel power sequencer

This block turns a requested backlight brightness, given as a percentage, into an ordered series of read-modify-write accesses to a display controller's register bank. Requests arrive on a small valid/ready command stream. A nonzero brightness runs the power-up path. It turns on automatic power-up, enables the panel PLL and then releases the PLL from reset. After settle delays it writes the general-control register with the panel enables and the 8-bit modulation level. A zero brightness runs the power-down path. That path gates the panel pixel clock through a companion indirect-access engine, disables the display, drops the panel enables, and finally restores the pixel-clock word.

The block also converts the stored 8-bit level back to a percentage. It returns that value on a valid/ready result stream. A suspend command saves the current percentage and powers the panel down. A resume command applies the saved percentage again. The register bank and the indirect engine are external. The block reaches them through a bus-master port that has one access outstanding at a time and a request/done handshake. All settle delays are exact cycle counts derived from the clock-frequency parameter.

Back-pressure rules: `req_ready` is high only while the sequencer is idle, and a command is taken on a clock edge where `req_valid` and `req_ready` are both high. A command offered and withdrawn while `req_ready` is low never runs. `rb_valid`, once raised, stays high with `rb_pct` unchanged until the edge where `rb_ready` is high.

Top module: `bl_pwr_seq`

## Requirements
- R1: A requested percentage above 100 is treated as 100, so inputs 100, 120 and 255 all produce level 255.
- R2: For a nonzero percentage p, the level is floor(p*5/2)+5. It is written into bits 15:8 of the general-control register at address 0x2D0, so p=1 gives 7, p=37 gives 97 and p=50 gives 130.
- R3: Power-up makes these accesses in order: a read of 0x2D0, a read of 0xD08, a write of 0xD08 with bit 26 set, a read of 0x2D4, a write of 0x2D4 with bit 16 set, and a second write of 0x2D4 with bit 16 set and bit 17 cleared.
- R4: At least CLK_HZ/1000 + CLK_HZ/5 cycles after the second 0x2D4 write, the block writes 0x2D0. That value has bits 1 and 15:8 cleared, then bits 0, 7, 16, 18 and 19 set, and the level placed in bits 15:8. The other bits come from the value read earlier.
- R5: A zero request first reads indirect index 0x2D, then writes that word back with bit 14 cleared.
- R6: Power-down then writes 0x2D0 twice. The first write has bit 1 set and bits 16 and 15:8 cleared. At least CLK_HZ/5 cycles later, the second write also has bits 0 and 7 cleared. The block then writes the saved word back to index 0x2D and stays busy for at least CLK_HZ/5 more cycles.
- R7: A read command returns floor((v-5)*2/5) for the level v in bits 15:8 of 0x2D0, and 0 when v is below 5. The result is held on rb_pct while rb_valid is high and rb_ready is low, so levels 7, 10, 97, 130 and 255 give 0, 2, 36, 50 and 100.
- R8: Suspend (op 2) captures the read-back percentage and runs the zero-request path. Resume (op 3) applies the captured value as a set request. The captured value is 0 after reset.
- R9: After reset, busy is low and req_ready is high. Busy stays high from acceptance until the last wait or result transfer ends, and commands offered while busy have no effect on the register bank. Op codes: 0 set, 1 read, 2 suspend, 3 resume.
- R10: m_rd and m_wr are never high together, and each stays high with a stable address and data until m_ready. ind_req stays high with stable fields until ind_done, and no access is made while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command offered |
| req_ready | output | 1 | Command can be taken (idle) |
| req_op | input | 2 | 0 set, 1 read, 2 suspend, 3 resume |
| req_pct | input | 8 | Requested percentage for set |
| rb_valid | output | 1 | Read-back percentage available |
| rb_ready | input | 1 | Read-back result taken |
| rb_pct | output | 7 | Read-back percentage 0..100 |
| busy | output | 1 | Sequence in progress |
| m_addr | output | ADDR_W | Register address |
| m_wdata | output | 32 | Write data |
| m_rdata | input | 32 | Read data, sampled with m_ready |
| m_rd | output | 1 | Read strobe |
| m_wr | output | 1 | Write strobe |
| m_ready | input | 1 | Access complete |
| ind_req | output | 1 | Indirect access request |
| ind_wr | output | 1 | Indirect access is a write |
| ind_idx | output | 6 | Indirect register index |
| ind_wdata | output | 32 | Indirect write data |
| ind_rdata | input | 32 | Indirect read data, sampled with ind_done |
| ind_done | input | 1 | Indirect access complete |

## Verification
The assertions check the handshake rules on every cycle: strobes and indirect requests held stable until acknowledged, read and write strobes exclusive, a quiet bus while idle, a held read-back result, and a wait counter that never overruns its load. The ordering and contents of the register writes, the level mapping in both directions, the minimum gaps between writes, the suspend/resume round trip and the discarding of commands offered while busy depend on whole sequences. Only the bench's scenarios, run against its register-bank model, can show those.

// File: rtl/bl_pkg.sv
package bl_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    OP_SET     = 2'd0,
    OP_READ    = 2'd1,
    OP_SUSPEND = 2'd2,
    OP_RESUME  = 2'd3
  } bl_op_e;

  typedef enum logic [4:0] {
    ST_IDLE, ST_RB_RD, ST_RB_OUT,
    ST_UP_GC_RD, ST_UP_PWR_RD, ST_UP_PWR_WR, ST_UP_PLL_RD,
    ST_UP_PLL_EN, ST_UP_PLL_RUN, ST_UP_WAIT_PLL, ST_UP_WAIT_PANEL, ST_UP_GC_WR,
    ST_DN_GC_RD, ST_DN_PIX_RD, ST_DN_PIX_OFF, ST_DN_GC_DIS, ST_DN_WAIT_OFF,
    ST_DN_GC_OFF, ST_DN_PIX_RST, ST_DN_WAIT_END
  } bl_state_e;

  localparam logic [15:0] A_PANEL_CTL = 16'h02D0;
  localparam logic [15:0] A_PANEL_PLL = 16'h02D4;
  localparam logic [15:0] A_DISP_PWR  = 16'h0D08;
  localparam logic [5:0]  IX_PIXCLK   = 6'h2D;

  localparam logic [31:0] M_ON      = 32'h0000_0001;
  localparam logic [31:0] M_DIS     = 32'h0000_0002;
  localparam logic [31:0] M_EN      = 32'h0000_0080;
  localparam logic [31:0] M_LVL     = 32'h0000_FF00;
  localparam logic [31:0] M_MOD     = 32'h0001_0000;
  localparam logic [31:0] M_DIGON   = 32'h0004_0000;
  localparam logic [31:0] M_BLON    = 32'h0008_0000;
  localparam logic [31:0] M_PLL_EN  = 32'h0001_0000;
  localparam logic [31:0] M_PLL_RST = 32'h0002_0000;
  localparam logic [31:0] M_AUTO_PU = 32'h0400_0000;
  localparam logic [31:0] M_PIX_AON = 32'h0000_4000;
endpackage

// File: rtl/bl_level_map.sv
module bl_level_map (
  input  logic [7:0] pct_in,
  input  logic [7:0] lvl_in,
  output logic [7:0] lvl_out,
  output logic [6:0] pct_out
);
  logic [7:0] pct_clamp;
  logic [9:0] lvl_wide;
  logic [8:0] back_wide;

  always_comb begin
    pct_clamp = (pct_in > 8'd100) ? 8'd100 : pct_in;
    lvl_wide  = ({2'b00, pct_clamp} * 10'd5) / 10'd2 + 10'd5;
    lvl_out   = (pct_clamp == 8'd0) ? 8'd0 : lvl_wide[7:0];
    back_wide = ({1'b0, lvl_in} - 9'd5) * 9'd2 / 9'd5;
    pct_out   = (lvl_in < 8'd5) ? 7'd0 : back_wide[6:0];
  end
endmodule

// File: rtl/bl_wait.sv
module bl_wait #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CNT_W-1:0] load,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  assign done = go && (cnt == load - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !go || done) cnt <= '0;
    else                       cnt <= cnt + CNT_W'(1);
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (cnt < load));
endmodule

// File: rtl/bl_pwr_seq.sv
module bl_pwr_seq
  import bl_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [7:0]        req_pct,
  output logic              rb_valid,
  input  logic              rb_ready,
  output logic [6:0]        rb_pct,
  output logic              busy,
  output logic [ADDR_W-1:0] m_addr,
  output logic [31:0]       m_wdata,
  input  logic [31:0]       m_rdata,
  output logic              m_rd,
  output logic              m_wr,
  input  logic              m_ready,
  output logic              ind_req,
  output logic              ind_wr,
  output logic [5:0]        ind_idx,
  output logic [31:0]       ind_wdata,
  input  logic [31:0]       ind_rdata,
  input  logic              ind_done
);
  localparam int WAIT_1MS   = CLK_HZ / 1000;
  localparam int WAIT_200MS = CLK_HZ / 5;
  localparam int CNT_W      = $clog2(WAIT_200MS + 1);

  bl_state_e  state;
  bl_op_e     op_q;
  logic [7:0] lvl_q;
  logic [6:0] saved_q, rb_q;
  logic [31:0] gc_q, work_q, pix_q;

  logic [7:0] pct_sel, lvl_map;
  logic [6:0] pct_map;
  logic       wait_go, wait_done;
  logic [CNT_W-1:0] wait_load;
  logic [31:0] gc_up, gc_dn;

  assign pct_sel = (bl_op_e'(req_op) == OP_RESUME) ? {1'b0, saved_q} : req_pct;

  bl_level_map u_map (
    .pct_in (pct_sel),
    .lvl_in (m_rdata[15:8]),
    .lvl_out(lvl_map),
    .pct_out(pct_map)
  );

  assign wait_go   = (state == ST_UP_WAIT_PLL) || (state == ST_UP_WAIT_PANEL) ||
                     (state == ST_DN_WAIT_OFF) || (state == ST_DN_WAIT_END);
  assign wait_load = (state == ST_UP_WAIT_PLL) ? CNT_W'(WAIT_1MS) : CNT_W'(WAIT_200MS);

  bl_wait #(.CNT_W(CNT_W)) u_wait (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (wait_go),
    .load (wait_load),
    .done (wait_done)
  );

  assign gc_up = (gc_q & ~(M_DIS | M_LVL)) | M_ON | M_EN | M_DIGON | M_BLON | M_MOD |
                 {16'd0, lvl_q, 8'd0};
  assign gc_dn = (gc_q | M_DIS) & ~(M_MOD | M_LVL);

  assign busy      = (state != ST_IDLE);
  assign req_ready = !busy;
  assign rb_valid  = (state == ST_RB_OUT);
  assign rb_pct    = rb_q;
  assign ind_idx   = IX_PIXCLK;

  always_comb begin
    m_rd = 1'b0; m_wr = 1'b0; m_addr = ADDR_W'(A_PANEL_CTL); m_wdata = '0;
    ind_req = 1'b0; ind_wr = 1'b0; ind_wdata = '0;
    unique case (state)
      ST_RB_RD, ST_UP_GC_RD, ST_DN_GC_RD: m_rd = 1'b1;
      ST_UP_PWR_RD: begin m_rd = 1'b1; m_addr = ADDR_W'(A_DISP_PWR); end
      ST_UP_PWR_WR: begin m_wr = 1'b1; m_addr = ADDR_W'(A_DISP_PWR); m_wdata = work_q | M_AUTO_PU; end
      ST_UP_PLL_RD: begin m_rd = 1'b1; m_addr = ADDR_W'(A_PANEL_PLL); end
      ST_UP_PLL_EN: begin m_wr = 1'b1; m_addr = ADDR_W'(A_PANEL_PLL); m_wdata = work_q | M_PLL_EN; end
      ST_UP_PLL_RUN: begin
        m_wr = 1'b1; m_addr = ADDR_W'(A_PANEL_PLL); m_wdata = (work_q | M_PLL_EN) & ~M_PLL_RST;
      end
      ST_UP_GC_WR:  begin m_wr = 1'b1; m_wdata = gc_up; end
      ST_DN_GC_DIS: begin m_wr = 1'b1; m_wdata = gc_dn; end
      ST_DN_GC_OFF: begin m_wr = 1'b1; m_wdata = gc_dn & ~(M_ON | M_EN); end
      ST_DN_PIX_RD: ind_req = 1'b1;
      ST_DN_PIX_OFF: begin ind_req = 1'b1; ind_wr = 1'b1; ind_wdata = pix_q & ~M_PIX_AON; end
      ST_DN_PIX_RST: begin ind_req = 1'b1; ind_wr = 1'b1; ind_wdata = pix_q; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE; op_q <= OP_SET; lvl_q <= '0; saved_q <= '0; rb_q <= '0;
      gc_q <= '0; work_q <= '0; pix_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          op_q  <= bl_op_e'(req_op);
          lvl_q <= lvl_map;
          if (bl_op_e'(req_op) == OP_READ || bl_op_e'(req_op) == OP_SUSPEND) state <= ST_RB_RD;
          else if (lvl_map == 8'd0) state <= ST_DN_GC_RD;
          else state <= ST_UP_GC_RD;
        end
        ST_RB_RD: if (m_ready) begin
          if (op_q == OP_SUSPEND) begin
            saved_q <= pct_map; gc_q <= m_rdata; state <= ST_DN_PIX_RD;
          end else begin
            rb_q <= pct_map; state <= ST_RB_OUT;
          end
        end
        ST_RB_OUT:    if (rb_ready) state <= ST_IDLE;
        ST_UP_GC_RD:  if (m_ready) begin gc_q <= m_rdata; state <= ST_UP_PWR_RD; end
        ST_UP_PWR_RD: if (m_ready) begin work_q <= m_rdata; state <= ST_UP_PWR_WR; end
        ST_UP_PWR_WR: if (m_ready) state <= ST_UP_PLL_RD;
        ST_UP_PLL_RD: if (m_ready) begin work_q <= m_rdata; state <= ST_UP_PLL_EN; end
        ST_UP_PLL_EN: if (m_ready) state <= ST_UP_PLL_RUN;
        ST_UP_PLL_RUN: if (m_ready) state <= ST_UP_WAIT_PLL;
        ST_UP_WAIT_PLL: if (wait_done) state <= ST_UP_WAIT_PANEL;
        ST_UP_WAIT_PANEL: if (wait_done) state <= ST_UP_GC_WR;
        ST_UP_GC_WR:  if (m_ready) state <= ST_IDLE;
        ST_DN_GC_RD:  if (m_ready) begin gc_q <= m_rdata; state <= ST_DN_PIX_RD; end
        ST_DN_PIX_RD: if (ind_done) begin pix_q <= ind_rdata; state <= ST_DN_PIX_OFF; end
        ST_DN_PIX_OFF: if (ind_done) state <= ST_DN_GC_DIS;
        ST_DN_GC_DIS: if (m_ready) state <= ST_DN_WAIT_OFF;
        ST_DN_WAIT_OFF: if (wait_done) state <= ST_DN_GC_OFF;
        ST_DN_GC_OFF: if (m_ready) state <= ST_DN_PIX_RST;
        ST_DN_PIX_RST: if (ind_done) state <= ST_DN_WAIT_END;
        ST_DN_WAIT_END: if (wait_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_rd && m_wr));
  p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wr && !m_ready) |=> (m_wr && $stable(m_addr) && $stable(m_wdata)));
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rd && !m_ready) |=> (m_rd && $stable(m_addr)));
  p_ind_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_req && !ind_done) |=> (ind_req && $stable(ind_wr) && $stable(ind_wdata)));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!m_rd && !m_wr && !ind_req));
  p_rb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_valid && !rb_ready) |=> (rb_valid && $stable(rb_pct)));
  p_rb_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid |-> (rb_pct <= 7'd100));
endmodule

// File: tb/test_bl_pwr_seq.sv
module test_bl_pwr_seq;
  localparam int CLK_HZ = 20000;
  localparam int D1 = CLK_HZ / 1000;
  localparam int D200 = CLK_HZ / 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid = 1'b0, req_ready, rb_valid, rb_ready = 1'b0, busy;
  logic [1:0] req_op = 2'd0;
  logic [7:0] req_pct = 8'd0;
  logic [6:0] rb_pct;
  logic [15:0] m_addr;
  logic [31:0] m_wdata, m_rdata, ind_wdata, ind_rdata;
  logic m_rd, m_wr, m_ready, ind_req, ind_wr, ind_done;
  logic [5:0] ind_idx;

  bl_pwr_seq #(.CLK_HZ(CLK_HZ), .ADDR_W(16)) i_bl_pwr_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_pct(req_pct), .rb_valid(rb_valid), .rb_ready(rb_ready),
    .rb_pct(rb_pct), .busy(busy), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .m_rd(m_rd), .m_wr(m_wr), .m_ready(m_ready),
    .ind_req(ind_req), .ind_wr(ind_wr), .ind_idx(ind_idx), .ind_wdata(ind_wdata),
    .ind_rdata(ind_rdata), .ind_done(ind_done)
  );

  // register bank model
  logic [31:0] r_gc = 32'h0000_0002, r_pll = 32'h0002_0000, r_pwr = 32'h0000_0011;
  logic [31:0] r_pix = 32'h0000_C0FF;
  logic bus_ack = 1'b0, ind_ack = 1'b0;
  int cyc = 0;
  int wcnt = 0, icnt = 0;
  logic [15:0] w_addr [64];
  logic [31:0] w_data [64];
  int w_t [64];
  logic [31:0] i_data [64];
  int i_t [64];
  logic [5:0] last_idx = '0;

  assign m_ready = bus_ack;
  assign ind_done = ind_ack;
  assign ind_rdata = r_pix;
  always_comb begin
    case (m_addr)
      16'h02D0: m_rdata = r_gc;
      16'h02D4: m_rdata = r_pll;
      16'h0D08: m_rdata = r_pwr;
      default:  m_rdata = 32'h0;
    endcase
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    bus_ack <= (m_rd || m_wr) && !bus_ack;
    ind_ack <= ind_req && !ind_ack;
    if (bus_ack && m_wr) begin
      if (m_addr == 16'h02D0) r_gc <= m_wdata;
      if (m_addr == 16'h02D4) r_pll <= m_wdata;
      if (m_addr == 16'h0D08) r_pwr <= m_wdata;
      if (wcnt < 64) begin w_addr[wcnt] <= m_addr; w_data[wcnt] <= m_wdata; w_t[wcnt] <= cyc; end
      wcnt <= wcnt + 1;
    end
    if (ind_ack) begin
      last_idx <= ind_idx;
      if (ind_wr) begin
        r_pix <= ind_wdata;
        if (icnt < 64) begin i_data[icnt] <= ind_wdata; i_t[icnt] <= cyc; end
        icnt <= icnt + 1;
      end
    end
  end

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [7:0] pct);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_pct = pct;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle(output int t_end);
    while (busy) @(negedge clk);
    t_end = cyc;
  endtask

  task automatic read_pct(output logic [6:0] pct);
    send(2'd1, 8'd0);
    while (!rb_valid) @(negedge clk);
    repeat (3) @(negedge clk);
    pct = rb_pct;
    rb_ready = 1'b1;
    @(negedge clk);
    rb_ready = 1'b0;
  endtask

  // pct in, expected level, expected read-back
  localparam logic [7:0] VEC [6][3] = '{
    '{8'd1,   8'd7,   8'd0},
    '{8'd50,  8'd130, 8'd50},
    '{8'd100, 8'd255, 8'd100},
    '{8'd120, 8'd255, 8'd100},
    '{8'd37,  8'd97,  8'd36},
    '{8'd2,   8'd10,  8'd2}
  };

  initial begin
    int t_end;
    logic [6:0] pct;
    logic [31:0] s_gc, s_pll, s_pwr, s_pix, exp_gc, d1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset busy", {31'd0, busy}, 32'd0);
    chk("R9 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R10 reset strobes", {30'd0, m_rd, m_wr}, 32'd0);

    for (int v = 0; v < 6; v++) begin
      s_gc = r_gc; s_pll = r_pll; s_pwr = r_pwr;
      wcnt = 0;
      send(2'd0, VEC[v][0]);
      wait_idle(t_end);
      chk("R3 write count", wcnt, 4);
      chk("R3 pwr addr", {16'd0, w_addr[0]}, 32'h0D08);
      chk("R3 pwr data", w_data[0], s_pwr | 32'h0400_0000);
      chk("R3 pll en", w_data[1], s_pll | 32'h0001_0000);
      chk("R3 pll run", w_data[2], (s_pll | 32'h0001_0000) & ~32'h0002_0000);
      chk("R3 pll addr", {16'd0, w_addr[2]}, 32'h02D4);
      exp_gc = (s_gc & ~32'h0000_FF02) | 32'h000D_0081 | {16'd0, VEC[v][1], 8'd0};
      chk("R1 R2 R4 gc data", w_data[3], exp_gc);
      chk("R4 settle gap", {31'd0, (w_t[3] - w_t[2]) >= D1 + D200}, 32'd1);
      read_pct(pct);
      chk("R7 read-back", {25'd0, pct}, {24'd0, VEC[v][2]});
    end

    // R1: 255 also saturates
    send(2'd0, 8'd255);
    wait_idle(t_end);
    chk("R1 clamp 255", {24'd0, r_gc[15:8]}, 32'd255);

    // R5 R6 power-down
    s_gc = r_gc; s_pix = r_pix;
    wcnt = 0; icnt = 0;
    send(2'd0, 8'd0);
    wait_idle(t_end);
    chk("R5 pix index", {26'd0, last_idx}, 32'h2D);
    chk("R5 pix off", i_data[0], s_pix & ~32'h0000_4000);
    d1 = (s_gc | 32'h2) & ~32'h0001_FF00;
    chk("R6 gc count", wcnt, 2);
    chk("R6 gc disable", w_data[0], d1);
    chk("R6 gc off", w_data[1], d1 & ~32'h81);
    chk("R6 gap", {31'd0, (w_t[1] - w_t[0]) >= D200}, 32'd1);
    chk("R6 pix restore", i_data[1], s_pix);
    chk("R6 trailing wait", {31'd0, (t_end - i_t[1]) >= D200}, 32'd1);
    read_pct(pct);
    chk("R7 zero level", {25'd0, pct}, 32'd0);

    // R9 command while busy is discarded
    send(2'd0, 8'd50);
    repeat (20) @(negedge clk);
    req_valid = 1'b1; req_op = 2'd0; req_pct = 8'd0;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle(t_end);
    wcnt = 0;
    repeat (40) @(negedge clk);
    chk("R9 no extra writes", wcnt, 0);
    chk("R9 level kept", {24'd0, r_gc[15:8]}, 32'd130);

    // R8 suspend / resume
    send(2'd2, 8'd0);
    wait_idle(t_end);
    chk("R8 suspend level", {24'd0, r_gc[15:8]}, 32'd0);
    chk("R8 suspend off", r_gc & 32'h81, 32'd0);
    send(2'd3, 8'd0);
    wait_idle(t_end);
    chk("R8 resume level", {24'd0, r_gc[15:8]}, 32'd130);
    read_pct(pct);
    chk("R8 resume pct", {25'd0, pct}, 32'd50);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule